// File: doc/BRIEF.md
# UART Receive Buffer with Status Flags

This block is the receive-side register front end of a UART. A receive shift register, which is not part of this block, hands it each finished character with a one-cycle strobe. The strobe comes with the character bits, the level of the first stop bit and a parity-mismatch indication. The block parks that character in a one-slot holding stage and moves it into a two-entry first-in first-out buffer on the next cycle when the buffer has room. Each buffered entry carries its own frame-error and parity-error bits. The error flags shown to software therefore always describe the character that the next data read will return.

Software sees two things. The first is a data output holding the oldest unread character; a data-read strobe pops it. The second is an 8-bit status word with a receive-complete flag, a frame-error flag, a parity-error flag and an overrun flag. Overrun is raised only when a start bit is detected while the buffer is full and the holding stage already carries a finished character. The receive-complete flag also drives an interrupt request through an enable input.

Top module: `uart_rx_buffer`

## Requirements
- R1: After synchronous reset the status word is 0x00, the data output is zero and the interrupt request is low.
- R2: A character strobed in while the buffer has a free entry enters the buffer two clock edges after the strobe cycle begins (holding stage, then buffer), and the receive-complete flag (status bit 0) is then set.
- R3: The overrun flag (status bit 3) is set only by a start-bit strobe in a cycle where the buffer holds two characters and the holding stage holds a finished one. A start-bit strobe while full with an empty holding stage leaves it clear.
- R4: The buffer holds two characters, and data reads return them oldest first. A read that frees a slot while a character waits in the holding stage moves that character in on the same edge.
- R5: The frame-error flag (status bit 1) is one exactly when the buffer is non-empty and the oldest character's first stop bit was zero. After a read it shows the next entry's stored value.
- R6: The parity-error flag (status bit 2) is one only when the parity-enable input is high and the oldest buffered character had a parity mismatch. Otherwise it reads zero.
- R7: The overrun flag stays set until a data read, which clears it. The error flags change only when the oldest entry changes.
- R8: A status write with bit 0 set clears the receive-complete flag without popping data. A read that empties the buffer also clears it. A status write with bit 0 clear changes nothing.
- R9: Status bits 7 to 4 always read zero.
- R10: The interrupt request is high exactly when the receive-complete flag and the interrupt-enable input are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_done | input | 1 | One-cycle strobe: a character has finished shifting in |
| char_data | input | DATA_W | Bits of the finished character |
| char_stop | input | 1 | Level sampled on the character's first stop bit |
| char_par_bad | input | 1 | Parity mismatch on the finished character |
| start_det | input | 1 | One-cycle strobe: a new start bit was detected |
| data_rd | input | 1 | Software read of the data register; pops the oldest character |
| stat_wr | input | 1 | Software write strobe for the status register |
| stat_wdata | input | 8 | Status write value; bit 0 set clears receive-complete |
| par_en | input | 1 | Parity checking enabled |
| rxc_ie | input | 1 | Receive-complete interrupt enable |
| data_out | output | DATA_W | Oldest unread character, zero when empty |
| status | output | 8 | Status: bit0 receive-complete, bit1 frame error, bit2 parity error, bit3 overrun, bits 7..4 zero |
| rxc_irq | output | 1 | Receive-complete interrupt request |

## Verification
The assertions check several rules on every cycle:
- an overrun rise has exactly the stated cause, and the flag holds until a read;
- parity errors vanish when checking is off;
- an empty buffer shows clean flags;
- any growth in fill level shows receive-complete;
- the interrupt request is never raised with an empty buffer or with the enable low.

Only the bench's scenarios can show the rest:
- first-in first-out order across the two entries;
- frame and parity bits following the right character after each pop;
- the pending character refilling the freed slot on the read edge;
- write-one-to-clear leaving data in place.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int STAT_W  = 8;
  localparam int ST_RXC  = 0;
  localparam int ST_FERR = 1;
  localparam int ST_PERR = 2;
  localparam int ST_OVF  = 3;
  // per-entry side bits appended below the character bits
  localparam int SIDE_W  = 2;
  localparam int SIDE_FE = 1;
  localparam int SIDE_PE = 0;
endpackage

// File: rtl/rxb_hold.sv
module rxb_hold #(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             take,
  input  logic [WIDTH-1:0] din,
  output logic             vld,
  output logic [WIDTH-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
    end else if (load) begin
      vld <= 1'b1;
    end else if (take) begin
      vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else if (load) begin
      dout <= din;
    end
  end
endmodule

// File: rtl/rxb_fifo.sv
module rxb_fifo #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic                       pop,
  input  logic [WIDTH-1:0]           wdata,
  output logic [WIDTH-1:0]           head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_ptr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      end
      if (pop) begin
        rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      end
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/rxb_flags.sv
module rxb_flags (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic pop,
  input  logic left_after_pop,
  input  logic w1c,
  input  logic ovf_set,
  output logic rxc,
  output logic ovf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rxc <= 1'b0;
    end else if (push) begin
      rxc <= 1'b1;
    end else if (w1c) begin
      rxc <= 1'b0;
    end else if (pop) begin
      rxc <= left_after_pop;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf <= 1'b0;
    end else if (ovf_set) begin
      ovf <= 1'b1;
    end else if (pop) begin
      ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              char_done,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_stop,
  input  logic              char_par_bad,
  input  logic              start_det,
  input  logic              data_rd,
  input  logic              stat_wr,
  input  logic [7:0]        stat_wdata,
  input  logic              par_en,
  input  logic              rxc_ie,
  output logic [DATA_W-1:0] data_out,
  output logic [7:0]        status,
  output logic              rxc_irq
);
  import rxb_pkg::*;

  localparam int ENT_W = DATA_W + SIDE_W;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ENT_W-1:0] new_ent, pend_ent, head_ent;
  logic             pend_vld, push, pop, full, empty;
  logic [CNT_W-1:0] fill_cnt;
  logic             rxc_q, ovf_q, ovf_set, w1c, left_after_pop;

  // Side bits: frame error is an inverted first stop bit.
  assign new_ent = {char_data, ~char_stop, char_par_bad};

  assign pop  = data_rd & ~empty;
  assign push = pend_vld & (~full | pop);

  assign ovf_set        = start_det & full & pend_vld;
  assign w1c            = stat_wr & stat_wdata[ST_RXC];
  assign left_after_pop = (fill_cnt != CNT_W'(1));

  rxb_hold #(.WIDTH(ENT_W)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .load (char_done),
    .take (push),
    .din  (new_ent),
    .vld  (pend_vld),
    .dout (pend_ent)
  );

  rxb_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .pop   (pop),
    .wdata (pend_ent),
    .head  (head_ent),
    .count (fill_cnt),
    .full  (full),
    .empty (empty)
  );

  rxb_flags u_flags (
    .clk            (clk),
    .rst            (rst),
    .push           (push),
    .pop            (pop),
    .left_after_pop (left_after_pop),
    .w1c            (w1c),
    .ovf_set        (ovf_set),
    .rxc            (rxc_q),
    .ovf            (ovf_q)
  );

  always_comb begin
    status          = '0;
    status[ST_RXC]  = rxc_q;
    status[ST_FERR] = ~empty & head_ent[SIDE_FE];
    status[ST_PERR] = ~empty & par_en & head_ent[SIDE_PE];
    status[ST_OVF]  = ovf_q;
  end

  assign data_out = empty ? '0 : head_ent[ENT_W-1:SIDE_W];
  assign rxc_irq  = rxc_q & rxc_ie;
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             data_rd,
  input logic             start_det,
  input logic             par_en,
  input logic             rxc_ie,
  input logic             rxc_irq,
  input logic [7:0]       status,
  input logic [CNT_W-1:0] fill_cnt,
  input logic             full,
  input logic             pend_vld
);
  import rxb_pkg::*;

  assert_ovf_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(status[ST_OVF]) |-> ($past(start_det) && $past(full) && $past(pend_vld)));

  assert_ovf_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (status[ST_OVF] && !data_rd) |=> status[ST_OVF]);

  assert_perr_gate_R6: assert property (@(posedge clk) disable iff (rst)
    !par_en |-> !status[ST_PERR]);

  assert_empty_clean_R5: assert property (@(posedge clk) disable iff (rst)
    (fill_cnt == '0) |-> (!status[ST_FERR] && !status[ST_PERR] && !status[ST_RXC]));

  assert_fill_rxc_R2: assert property (@(posedge clk) disable iff (rst)
    (fill_cnt > $past(fill_cnt)) |-> status[ST_RXC]);

  assert_irq_data_R10: assert property (@(posedge clk) disable iff (rst)
    rxc_irq |-> ((fill_cnt != '0) && rxc_ie));
endmodule

bind uart_rx_buffer rxb_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .data_rd   (data_rd),
  .start_det (start_det),
  .par_en    (par_en),
  .rxc_ie    (rxc_ie),
  .rxc_irq   (rxc_irq),
  .status    (status),
  .fill_cnt  (fill_cnt),
  .full      (full),
  .pend_vld  (pend_vld)
);

// File: tb/tb_uart_rx_buffer.sv
module tb_uart_rx_buffer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       char_done = 1'b0;
  logic [7:0] char_data = '0;
  logic       char_stop = 1'b1;
  logic       char_par_bad = 1'b0;
  logic       start_det = 1'b0;
  logic       data_rd = 1'b0;
  logic       stat_wr = 1'b0;
  logic [7:0] stat_wdata = '0;
  logic       par_en = 1'b0;
  logic       rxc_ie = 1'b0;
  logic [7:0] data_out;
  logic [7:0] status;
  logic       rxc_irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  uart_rx_buffer dut (
    .clk(clk), .rst(rst), .char_done(char_done), .char_data(char_data),
    .char_stop(char_stop), .char_par_bad(char_par_bad), .start_det(start_det),
    .data_rd(data_rd), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .par_en(par_en), .rxc_ie(rxc_ie), .data_out(data_out),
    .status(status), .rxc_irq(rxc_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // All tasks start and end just after a falling edge.
  task automatic send(input logic [7:0] d, input logic stop, input logic pbad);
    char_data = d; char_stop = stop; char_par_bad = pbad; char_done = 1'b1;
    @(negedge clk);
    char_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start_det = 1'b1;
    @(negedge clk);
    start_det = 1'b0;
  endtask

  task automatic do_read(output logic [7:0] got);
    got = data_out;
    data_rd = 1'b1;
    @(negedge clk);
    data_rd = 1'b0;
  endtask

  task automatic wr_status(input logic [7:0] v);
    stat_wdata = v; stat_wr = 1'b1;
    @(negedge clk);
    stat_wr = 1'b0; stat_wdata = '0;
  endtask

  task automatic t_reset();
    chk_eq("R1 status", status, 8'h00);
    chk_eq("R1 data", data_out, 8'h00);
    chk_eq("R1 irq", rxc_irq, 0);
  endtask

  task automatic t_single();
    logic [7:0] g;
    send(8'hA5, 1'b1, 1'b0);
    chk_eq("R2 status after arrival", status, 8'h01);
    chk_eq("R2 data after arrival", data_out, 8'hA5);
    chk_eq("R10 irq disabled", rxc_irq, 0);
    rxc_ie = 1'b1; #1;
    chk_eq("R10 irq enabled", rxc_irq, 1);
    do_read(g);
    chk_eq("R4 read value", g, 8'hA5);
    chk_eq("R8 status after emptying read", status, 8'h00);
    chk_eq("R10 irq after read", rxc_irq, 0);
    rxc_ie = 1'b0;
  endtask

  task automatic t_frame();
    logic [7:0] g;
    send(8'h11, 1'b0, 1'b0);
    send(8'h22, 1'b1, 1'b0);
    chk_eq("R5 ferr on first entry", status, 8'h03);
    wr_status(8'hFE);
    chk_eq("R8 write without bit0 ignored", status, 8'h03);
    chk_eq("R7 data unchanged by write", data_out, 8'h11);
    do_read(g);
    chk_eq("R4 oldest first", g, 8'h11);
    chk_eq("R5 ferr follows next entry", status, 8'h01);
    chk_eq("R4 second entry visible", data_out, 8'h22);
    do_read(g);
    chk_eq("R4 second read", g, 8'h22);
    chk_eq("R8 empty after two reads", status, 8'h00);
  endtask

  task automatic t_parity();
    logic [7:0] g;
    par_en = 1'b0;
    send(8'h33, 1'b1, 1'b1);
    chk_eq("R6 perr masked when disabled", status, 8'h01);
    par_en = 1'b1; #1;
    chk_eq("R6 perr shown when enabled", status, 8'h05);
    wr_status(8'h01);
    chk_eq("R8 w1c clears rxc only", status, 8'h04);
    chk_eq("R8 w1c keeps data", data_out, 8'h33);
    do_read(g);
    chk_eq("R8 read after w1c value", g, 8'h33);
    chk_eq("R6 clean after pop", status, 8'h00);
    par_en = 1'b0;
  endtask

  task automatic t_overflow();
    logic [7:0] g;
    send(8'h41, 1'b1, 1'b0);
    send(8'h42, 1'b1, 1'b0);
    pulse_start();
    chk_eq("R3 full but no pending: no overrun", status, 8'h01);
    send(8'h43, 1'b1, 1'b0);
    chk_eq("R4 third waits, head unchanged", data_out, 8'h41);
    chk_eq("R3 no overrun before start", status, 8'h01);
    pulse_start();
    chk_eq("R3 overrun set", status, 8'h09);
    chk_eq("R9 upper bits zero", status & 8'hF0, 8'h00);
    repeat (3) @(negedge clk);
    chk_eq("R7 overrun held", status, 8'h09);
    do_read(g);
    chk_eq("R4 read oldest on overrun", g, 8'h41);
    chk_eq("R7 overrun cleared by read", status, 8'h01);
    chk_eq("R4 next head", data_out, 8'h42);
    do_read(g);
    chk_eq("R4 pending refilled slot", data_out, 8'h43);
    do_read(g);
    chk_eq("R4 last char", g, 8'h43);
    chk_eq("R8 empty at end", status, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_frame();
    t_parity();
    t_overflow();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule